// File: doc/BRIEF.md
# Width-Configurable Static RAM Device Emulator

This block is a synthesizable, cycle-level stand-in for an asynchronous static RAM. It sits on the device side of a memory controller testbench or an FPGA prototype. It decodes two chip selects, one active low and one active high, plus write enable, output enable and two byte-lane strobes. From these it works out, on every cycle, which lanes it drives and which lanes it writes. Storage is a byte array whose depth follows a parameter. The three-state data pins are modelled as separate input, output and per-pin drive-enable vectors.

A static organisation pin selects how the device is seen. Tied high, the device is 16 bits wide: word `n` occupies bytes `2n` (low lane) and `2n+1` (high lane). Tied low, the device is 8 bits wide with twice as many locations. In that case data pin 15 becomes the most significant address bit, pins 8 to 14 are idle, and the byte strobes no longer matter. Analog timing is replaced by a simple cycle rule. A write commits once, on the first clock edge at which the write condition is seen. Read data follows the address and enables combinationally.

The emulator also raises a contention flag when the external bus reports that it is driving a lane the emulator is driving.

Top module: `sram_emu`

## Requirements
- R1: With `org_wide`=1, a write with both strobes low stores `dq_in[15:0]` at the word address, and a read with `oe_n`=0 drives the stored word on `dq_out` with `dq_oe`=16'hFFFF.
- R2: With `org_wide`=1, word address n maps to byte n*2 (bits 7:0) and byte n*2+1 (bits 15:8). With `org_wide`=0, the byte address is `{dq_in[15], addr}`, data uses pins 7:0 only (`dq_oe`=16'h00FF on a read), pins 15:8 are never driven, and both strobes are ignored.
- R3: When deselected (`cs_n`=1 or `cs_en`=0), `dq_oe` is 0 whatever the other controls are.
- R4: During a selected read with `oe_n`=1, `dq_oe` is 0.
- R5: While `we_n`=0 and the device is selected, `dq_oe` is 0 even with `oe_n`=0.
- R6: With `org_wide`=1, the low lane (pins 7:0) is read or written only when `lane_lo_n`=0, and the high lane (pins 15:8) only when `lane_hi_n`=0. A lane whose strobe is high is left undriven and unwritten.
- R7: A write commits exactly once, on the first rising clock edge at which the write condition (selected, `we_n`=0, at least one lane enabled) is seen. Data changed while the condition stays asserted is not stored.
- R8: Read data on `dq_out` follows a change of `addr` in the same cycle, with no clock edge.
- R9: `bus_err` is 1 exactly when `ext_drv[0]` is 1 while pins 7:0 are driven, or `ext_drv[1]` is 1 while pins 15:8 are driven.
- R10: `dq_out` bits whose `dq_oe` bit is 0 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for write commit sampling |
| rst | input | 1 | Synchronous active-high reset of the write-edge sampler |
| org_wide | input | 1 | Organisation strap: 1 = 16-bit words, 0 = 8-bit bytes |
| cs_n | input | 1 | Active-low chip select |
| cs_en | input | 1 | Active-high chip select |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| lane_lo_n | input | 1 | Active-low low-lane strobe (pins 7:0) |
| lane_hi_n | input | 1 | Active-low high-lane strobe (pins 15:8) |
| addr | input | ADDR_W | Word address (byte address low bits in 8-bit mode) |
| dq_in | input | 16 | Value seen on the data pins from the bus |
| ext_drv | input | 2 | Per-lane flag that the external bus is driving |
| dq_out | output | 16 | Value the emulator puts on the data pins |
| dq_oe | output | 16 | Per-pin drive enable of the emulator |
| bus_err | output | 1 | Lane contention flag |

## Verification
The bound checker watches, on every cycle, the release rules: no drive when deselected, with output enable high, or during a write; no upper-lane drive in 8-bit mode or with the high strobe off. It also checks that a commit pulse lasts one cycle and only occurs inside a write, and that the contention flag only rises on a lane that both sides drive. What was actually stored can only be shown by the bench's scenarios. These cover the word-to-byte mapping across the two organisations, the address bit taken from pin 15, partial-lane writes, and the single commit under a held write with changing data.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int BUS_W  = LANE_W * LANES;

    typedef enum logic {
        ORG_NARROW = 1'b0,
        ORG_WIDE   = 1'b1
    } org_e;

    typedef struct packed {
        logic drive;
        logic write;
    } lane_ctl_t;

    function automatic org_e org_from_pin(input logic pin);
        return pin ? ORG_WIDE : ORG_NARROW;
    endfunction

    // lane usable in a given organisation given its active-low strobe
    function automatic logic lane_usable(input org_e org, input int lane, input logic stb_n);
        if (org == ORG_WIDE) begin
            return ~stb_n;
        end
        return (lane == 0);
    endfunction

endpackage

// File: rtl/sram_emu_decode.sv
module sram_emu_decode
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 7,
    localparam int BA_W  = ADDR_W + 1
) (
    input  logic                            org_wide,
    input  logic                            cs_n,
    input  logic                            cs_en,
    input  logic                            we_n,
    input  logic                            oe_n,
    input  logic [LANES-1:0]                stb_n,
    input  logic [ADDR_W-1:0]               addr,
    input  logic                            top_pin,
    output lane_ctl_t [LANES-1:0]           ctl,
    output logic [LANES-1:0][BA_W-1:0]      byte_addr,
    output logic                            wr_cond
);

    org_e org;
    logic selected;
    logic [LANES-1:0] usable;
    logic [LANES-1:0] wr_vec;

    always_comb begin
        org      = org_from_pin(org_wide);
        selected = ~cs_n & cs_en;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            usable[l]       = lane_usable(org, l, stb_n[l]);
            ctl[l].drive    = selected & we_n & ~oe_n & usable[l];
            ctl[l].write    = selected & ~we_n & usable[l];
            wr_vec[l]       = ctl[l].write;
            if (org == ORG_WIDE) begin
                byte_addr[l] = {addr, 1'(l)};
            end else begin
                byte_addr[l] = {top_pin, addr};
            end
        end
    end

    assign wr_cond = |wr_vec;

endmodule

// File: rtl/sram_emu_wedge.sv
module sram_emu_wedge (
    input  logic clk,
    input  logic rst,
    input  logic wr_cond,
    output logic commit
);

    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= wr_cond;
        end
    end

    assign commit = wr_cond & ~seen_q;

endmodule

// File: rtl/sram_emu_array.sv
module sram_emu_array
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 7,
    localparam int BA_W  = ADDR_W + 1,
    localparam int DEPTH = 1 << BA_W
) (
    input  logic                             clk,
    input  logic                             commit,
    input  lane_ctl_t [LANES-1:0]            ctl,
    input  logic [LANES-1:0][BA_W-1:0]       byte_addr,
    input  logic [LANES-1:0][LANE_W-1:0]     wdata,
    output logic [LANES-1:0][LANE_W-1:0]     rdata
);

    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int l = 0; l < LANES; l++) begin
                if (ctl[l].write) begin
                    mem[byte_addr[l]] <= wdata[l];
                end
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_rd
        assign rdata[l] = mem[byte_addr[l]];
    end

endmodule

// File: rtl/sram_emu_bus.sv
module sram_emu_bus
    import sram_emu_pkg::*;
(
    input  lane_ctl_t [LANES-1:0]           ctl,
    input  logic [LANES-1:0][LANE_W-1:0]    rdata,
    input  logic [LANES-1:0]                ext_drv,
    output logic [BUS_W-1:0]                dq_out,
    output logic [BUS_W-1:0]                dq_oe,
    output logic                            bus_err
);

    logic [LANES-1:0] clash;

    for (genvar l = 0; l < LANES; l++) begin : g_pin
        assign dq_oe [l*LANE_W +: LANE_W] = {LANE_W{ctl[l].drive}};
        assign dq_out[l*LANE_W +: LANE_W] = ctl[l].drive ? rdata[l] : '0;
        assign clash[l] = ctl[l].drive & ext_drv[l];
    end

    assign bus_err = |clash;

endmodule

// File: rtl/sram_emu.sv
module sram_emu
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              org_wide,
    input  logic              cs_n,
    input  logic              cs_en,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              lane_lo_n,
    input  logic              lane_hi_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    input  logic [1:0]        ext_drv,
    output logic [15:0]       dq_out,
    output logic [15:0]       dq_oe,
    output logic              bus_err
);

    localparam int BA_W = ADDR_W + 1;

    lane_ctl_t [LANES-1:0]          ctl;
    logic [LANES-1:0][BA_W-1:0]     byte_addr;
    logic [LANES-1:0][LANE_W-1:0]   wdata;
    logic [LANES-1:0][LANE_W-1:0]   rdata;
    logic                           wr_cond;
    logic                           wr_commit;

    assign wdata = dq_in;

    sram_emu_decode #(.ADDR_W(ADDR_W)) u_dec (
        .org_wide (org_wide),
        .cs_n     (cs_n),
        .cs_en    (cs_en),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .stb_n    ({lane_hi_n, lane_lo_n}),
        .addr     (addr),
        .top_pin  (dq_in[BUS_W-1]),
        .ctl      (ctl),
        .byte_addr(byte_addr),
        .wr_cond  (wr_cond)
    );

    sram_emu_wedge u_edge (
        .clk    (clk),
        .rst    (rst),
        .wr_cond(wr_cond),
        .commit (wr_commit)
    );

    sram_emu_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk      (clk),
        .commit   (wr_commit),
        .ctl      (ctl),
        .byte_addr(byte_addr),
        .wdata    (wdata),
        .rdata    (rdata)
    );

    sram_emu_bus u_bus (
        .ctl    (ctl),
        .rdata  (rdata),
        .ext_drv(ext_drv),
        .dq_out (dq_out),
        .dq_oe  (dq_oe),
        .bus_err(bus_err)
    );

endmodule

// File: rtl/sram_emu_chk.sv
module sram_emu_chk (
    input logic        clk,
    input logic        rst,
    input logic        org_wide,
    input logic        cs_n,
    input logic        cs_en,
    input logic        we_n,
    input logic        oe_n,
    input logic        lane_hi_n,
    input logic [1:0]  ext_drv,
    input logic [15:0] dq_oe,
    input logic        bus_err,
    input logic        commit
);

    // R3: deselected means no pin driven
    a_r3_deselect_release: assert property (@(posedge clk) disable iff (rst)
        (cs_n || !cs_en) |-> (dq_oe == 16'h0));

    // R4: output enable high releases the pins
    a_r4_oe_high_release: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (dq_oe == 16'h0));

    // R5: no drive during a write
    a_r5_write_release: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (dq_oe == 16'h0));

    // R2: upper pins idle in narrow organisation
    a_r2_narrow_upper_idle: assert property (@(posedge clk) disable iff (rst)
        !org_wide |-> (dq_oe[15:8] == 8'h0));

    // R6: high strobe off keeps high lane released
    a_r6_hi_lane_release: assert property (@(posedge clk) disable iff (rst)
        (org_wide && lane_hi_n) |-> (dq_oe[15:8] == 8'h0));

    // R7: commit is a single-cycle pulse
    a_r7_single_commit: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);

    // R7: commit only inside a selected write
    a_r7_commit_in_write: assert property (@(posedge clk) disable iff (rst)
        commit |-> (!we_n && !cs_n && cs_en));

    // R9: contention only on a lane both sides drive
    a_r9_clash_source: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> ((ext_drv[0] && dq_oe[0]) || (ext_drv[1] && dq_oe[8])));

endmodule

bind sram_emu sram_emu_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .org_wide (org_wide),
    .cs_n     (cs_n),
    .cs_en    (cs_en),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .lane_hi_n(lane_hi_n),
    .ext_drv  (ext_drv),
    .dq_oe    (dq_oe),
    .bus_err  (bus_err),
    .commit   (wr_commit)
);

// File: tb/sram_emu_test.sv
module sram_emu_test;

    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst;
    logic          org_wide, cs_n, cs_en, we_n, oe_n, lane_lo_n, lane_hi_n;
    logic [AW-1:0] addr;
    logic [15:0]   dq_in;
    logic [1:0]    ext_drv;
    logic [15:0]   dq_out, dq_oe;
    logic          bus_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    sram_emu #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .org_wide(org_wide), .cs_n(cs_n), .cs_en(cs_en),
        .we_n(we_n), .oe_n(oe_n), .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n),
        .addr(addr), .dq_in(dq_in), .ext_drv(ext_drv),
        .dq_out(dq_out), .dq_oe(dq_oe), .bus_err(bus_err)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        cs_n = 1'b1; cs_en = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        lane_lo_n = 1'b0; lane_hi_n = 1'b0; ext_drv = 2'b00;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d,
                      input logic lo_n, input logic hi_n);
        @(negedge clk);
        cs_n = 1'b0; cs_en = 1'b1; oe_n = 1'b1; we_n = 1'b0;
        addr = a; dq_in = d; lane_lo_n = lo_n; lane_hi_n = hi_n;
        @(negedge clk);
        we_n = 1'b1; lane_lo_n = 1'b0; lane_hi_n = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic top);
        @(negedge clk);
        cs_n = 1'b0; cs_en = 1'b1; we_n = 1'b1; oe_n = 1'b0;
        addr = a; dq_in = {top, 15'h0};
        #1;
    endtask

    task automatic t_reset();
        idle(); org_wide = 1'b1; addr = '0; dq_in = '0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R3 reset idle dq_oe", dq_oe, 16'h0);
        check("R9 reset idle bus_err", {15'h0, bus_err}, 16'h0);
    endtask

    task automatic t_wide_rw();
        org_wide = 1'b1;
        wr(7'd5, 16'hBEEF, 1'b0, 1'b0);
        rd(7'd5, 1'b0);
        check("R1 wide read data", dq_out, 16'hBEEF);
        check("R1 wide read dq_oe", dq_oe, 16'hFFFF);
        idle();
    endtask

    task automatic t_map_narrow();
        org_wide = 1'b0;
        rd(7'd10, 1'b0);
        check("R2 byte 10 from word 5 low", dq_out, 16'h00EF);
        check("R2 narrow dq_oe", dq_oe, 16'h00FF);
        rd(7'd11, 1'b0);
        check("R2 byte 11 from word 5 high", dq_out, 16'h00BE);
        // pin 15 as top address bit, strobes high ignored
        wr(7'd10, 16'h8055, 1'b1, 1'b1);
        rd(7'd10, 1'b0);
        check("R2 byte 10 unchanged by top-bank write", dq_out, 16'h00EF);
        rd(7'd10, 1'b1);
        check("R2 byte 138 via pin 15", dq_out, 16'h0055);
        org_wide = 1'b1;
        rd(7'd69, 1'b0);
        check("R2 byte 138 seen as word 69 low", dq_out & 16'h00FF, 16'h0055);
        idle();
    endtask

    task automatic t_deselect();
        org_wide = 1'b1;
        rd(7'd5, 1'b0);
        cs_n = 1'b1; #1;
        check("R3 cs_n high releases", dq_oe, 16'h0);
        cs_n = 1'b0; cs_en = 1'b0; #1;
        check("R3 cs_en low releases", dq_oe, 16'h0);
        check("R10 released pins read 0", dq_out, 16'h0);
        idle();
    endtask

    task automatic t_oe_high();
        rd(7'd5, 1'b0);
        oe_n = 1'b1; #1;
        check("R4 oe_n high releases", dq_oe, 16'h0);
        idle();
    endtask

    task automatic t_write_nodrive();
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; addr = 7'd20; dq_in = 16'h1111;
        #1;
        check("R5 no drive in write with oe_n low", dq_oe, 16'h0);
        @(negedge clk);
        we_n = 1'b1; #1;
        check("R5 written then read", dq_out, 16'h1111);
        idle();
    endtask

    task automatic t_lanes();
        org_wide = 1'b1;
        wr(7'd3, 16'h1234, 1'b0, 1'b0);
        wr(7'd3, 16'hABCD, 1'b1, 1'b0);
        rd(7'd3, 1'b0);
        check("R6 high-only write", dq_out, 16'hAB34);
        lane_hi_n = 1'b1; #1;
        check("R6 low-only read dq_oe", dq_oe, 16'h00FF);
        check("R10 low-only read dq_out", dq_out, 16'h0034);
        lane_hi_n = 1'b0; lane_lo_n = 1'b1; #1;
        check("R6 high-only read dq_oe", dq_oe, 16'hFF00);
        idle();
    endtask

    task automatic t_commit_once();
        org_wide = 1'b1;
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = 7'd40; dq_in = 16'hAAAA;
        @(negedge clk);
        dq_in = 16'h5555;
        @(negedge clk);
        we_n = 1'b1;
        rd(7'd40, 1'b0);
        check("R7 held write stores first data only", dq_out, 16'hAAAA);
        idle();
    endtask

    task automatic t_comb_read();
        org_wide = 1'b1;
        rd(7'd3, 1'b0);
        addr = 7'd5; #1;
        check("R8 address change without clock", dq_out, 16'hBEEF);
        idle();
    endtask

    task automatic t_clash();
        org_wide = 1'b1;
        rd(7'd5, 1'b0);
        ext_drv = 2'b01; #1;
        check("R9 low lane clash", {15'h0, bus_err}, 16'h1);
        lane_hi_n = 1'b1; ext_drv = 2'b10; #1;
        check("R9 high lane released no clash", {15'h0, bus_err}, 16'h0);
        oe_n = 1'b1; ext_drv = 2'b11; #1;
        check("R9 no drive no clash", {15'h0, bus_err}, 16'h0);
        idle();
    endtask

    initial begin
        t_reset();
        t_wide_rw();
        t_map_narrow();
        t_deselect();
        t_oe_high();
        t_write_nodrive();
        t_lanes();
        t_commit_once();
        t_comb_read();
        t_clash();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule